// File: doc/BRIEF.md
# Near-Memory Atomic Operation Unit

This block sits next to a memory controller and carries out single-word atomic read-modify-write commands at the word's home node. Commands wait in an external queue; the unit pops one only when it is idle. Each command names an operation (increment or fetch-and-add), a word address, an addend, an optional compare value with its enable bit, and a requester tag. The unit answers every command with the value the word held before the operation, tagged with the requester's tag.

Synchronization words are kept in a small fully associative word store inside the unit, so repeated operations on the same counter combine there. A miss sends a word-grained read request outward and waits for the returned coherent value before operating. Word-grained write requests go outward in three cases: every fetch-and-add (so cached copies see the new value at once), any operation whose result matches an enabled compare value (so a barrier counter produces a single update when the last participant arrives), and the write-back of a modified word being replaced. A resident word may be changed without first obtaining exclusive ownership of its block.

Top module: `atomic_unit`

## Requirements
- R1: Opcode value 0 (increment) stores old+1 in the addressed word and returns the old value on `rsp_data`.
- R2: Opcode value 1 (fetch-and-add) stores old+`cmd_operand` modulo 2^DW, returns the old value, and pulses `put_valid` with the word's address and new value in the same cycle as `rsp_valid`.
- R3: With `cmd_test_en`=1, a write request carrying the result is issued in the response cycle exactly when the result equals `cmd_test`; on a mismatch an increment issues none.
- R4: With `cmd_test_en`=0, an increment issues no write request even if its result equals `cmd_test`.
- R5: A command that finds its word resident is accepted at one rising edge and its response is valid after the next rising edge (two cycles), with `rsp_tag` equal to the command's tag and no read request.
- R6: `cmd_ready` is high only when the unit is idle: it drops in the cycle after a command is accepted and returns high in the cycle the response is valid, so at most one command is in flight.
- R7: A command whose word is not resident pulses `get_valid` with the word address in the cycle after acceptance; the operation is applied to the value returned on `fill_data` (with `fill_valid`) and the response follows the fill.
- R8: The store holds ENTRIES (default 8) words; while a word stays resident, further operations on it cause no read requests and no write requests other than those required by R2 and R3.
- R9: A miss fills an empty entry if one exists; when all entries are occupied it replaces the least recently operated-on word.
- R10: A replaced word that was modified since it last left the unit is written back: `put_valid` pulses with its address and current value in the same cycle as the miss's `get_valid`.
- R11: A word whose latest value already went out by a write request (R2, R3), or that was only filled, is replaced without a write-back.
- R12: After reset `cmd_ready` is 1, `rsp_valid`, `get_valid` and `put_valid` are 0, and the word store is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command queue holds a command |
| cmd_ready | output | 1 | Unit pops the queue head this cycle |
| cmd_op | input | 1 | 0 = increment, 1 = fetch-and-add |
| cmd_addr | input | AW | Word address |
| cmd_operand | input | DW | Addend for fetch-and-add |
| cmd_test_en | input | 1 | Enables the result comparison |
| cmd_test | input | DW | Compare value |
| cmd_tag | input | TW | Requester tag |
| rsp_valid | output | 1 | Response pulse |
| rsp_tag | output | TW | Tag of the answered command |
| rsp_data | output | DW | Word value before the operation |
| get_valid | output | 1 | Word read request pulse |
| get_addr | output | AW | Address to read |
| fill_valid | input | 1 | Read data returned |
| fill_data | input | DW | Returned coherent word value |
| put_valid | output | 1 | Word write request pulse |
| put_addr | output | AW | Address to write |
| put_data | output | DW | Value to write |

## Verification
The one cycle in which two outward requests coincide is a miss that must replace a modified word: the write-back and the read for the new address leave together. The bench provokes it by filling all eight entries, dirtying some with increments, and then touching fresh addresses so that both clean and dirty words are chosen as victims. A reference list kept in recency order predicts the victim and whether it is dirty; the bench then requires the write-back address and value to agree with its own running model in that same cycle as the read, and requires the re-read of an evicted word to return the written-back value.

// File: rtl/atom_pkg.sv
package atom_pkg;
  typedef enum logic {
    OP_INC  = 1'b0,
    OP_FADD = 1'b1
  } atom_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } atom_state_e;
endpackage

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int DW = 32
) (
  input  atom_op_e        op,
  input  logic [DW-1:0]   old_val,
  input  logic [DW-1:0]   operand,
  input  logic            test_en,
  input  logic [DW-1:0]   test_val,
  output logic [DW-1:0]   new_val,
  output logic            push
);
  logic [DW-1:0] addend;

  always_comb begin
    addend  = (op == OP_FADD) ? operand : DW'(1);
    new_val = old_val + addend;
    push    = (op == OP_FADD) || (test_en && (new_val == test_val));
  end
endmodule

// File: rtl/atom_word_cache.sv
module atom_word_cache #(
  parameter int ENTRIES = 8,
  parameter int AW      = 16,
  parameter int DW      = 32,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_addr,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [DW-1:0] rd_data,
  output logic [IW-1:0] vic_idx,
  output logic          vic_dirty,
  output logic [AW-1:0] vic_tag,
  output logic [DW-1:0] vic_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_dirty,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [ENTRIES-1:0] match;
  logic [AW-1:0]      tag_q [ENTRIES];
  logic [IW-1:0]      age_q [ENTRIES];
  logic [DW-1:0]      mem   [ENTRIES];
  logic               any_free;
  logic [IW-1:0]      free_idx;
  logic [IW-1:0]      lru_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign match[g] = valid_q[g] && (tag_q[g] == lk_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = IW'(i);
    hit = |match;
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    lru_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == IW'(ENTRIES - 1)) lru_idx = IW'(i);
    vic_idx = any_free ? free_idx : lru_idx;
  end

  assign rd_data   = mem[hit_idx];
  assign vic_dirty = valid_q[vic_idx] && dirty_q[vic_idx];
  assign vic_tag   = tag_q[vic_idx];
  assign vic_data  = mem[vic_idx];

  // data array: plain write port, no reset, so it maps to a RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        age_q[i] <= IW'(i);
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && (wr_idx == IW'(i))) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= wr_dirty;
          tag_q[i]   <= wr_tag;
        end
        if (touch_en) begin
          if (touch_idx == IW'(i))
            age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx])
            age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  // R8
  no_double_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R9
  touch_youngest_chk: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (age_q[$past(touch_idx)] == '0));
endmodule

// File: rtl/atomic_unit.sv
module atomic_unit
  import atom_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int TW      = 4,
  parameter int ENTRIES = 8,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_operand,
  input  logic          cmd_test_en,
  input  logic [DW-1:0] cmd_test,
  input  logic [TW-1:0] cmd_tag,
  output logic          rsp_valid,
  output logic [TW-1:0] rsp_tag,
  output logic [DW-1:0] rsp_data,
  output logic          get_valid,
  output logic [AW-1:0] get_addr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  output logic          put_valid,
  output logic [AW-1:0] put_addr,
  output logic [DW-1:0] put_data
);
  atom_state_e   state;
  atom_op_e      c_op;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_opnd;
  logic          c_ten;
  logic [DW-1:0] c_test;
  logic [TW-1:0] c_tag;
  logic [IW-1:0] vic_q;

  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [DW-1:0] rd_data;
  logic [IW-1:0] vic_idx;
  logic          vic_dirty;
  logic [AW-1:0] vic_tag;
  logic [DW-1:0] vic_data;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic          wr_dirty;
  logic          touch_en;
  logic [DW-1:0] new_val;
  logic          push;

  assign cmd_ready = (state == ST_IDLE);

  atom_alu #(.DW(DW)) i_alu (
    .op       (c_op),
    .old_val  (rd_data),
    .operand  (c_opnd),
    .test_en  (c_ten),
    .test_val (c_test),
    .new_val  (new_val),
    .push     (push)
  );

  atom_word_cache #(.ENTRIES(ENTRIES), .AW(AW), .DW(DW)) i_store (
    .clk       (clk),
    .rst       (rst),
    .lk_addr   (c_addr),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .rd_data   (rd_data),
    .vic_idx   (vic_idx),
    .vic_dirty (vic_dirty),
    .vic_tag   (vic_tag),
    .vic_data  (vic_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_tag    (c_addr),
    .wr_data   (wr_data),
    .wr_dirty  (wr_dirty),
    .touch_en  (touch_en),
    .touch_idx (hit_idx)
  );

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = hit_idx;
    wr_data  = new_val;
    wr_dirty = !push;
    touch_en = 1'b0;
    if (state == ST_LOOK && hit) begin
      wr_en    = 1'b1;
      touch_en = 1'b1;
    end else if (state == ST_WAIT && fill_valid) begin
      wr_en    = 1'b1;
      wr_idx   = vic_q;
      wr_data  = fill_data;
      wr_dirty = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      c_op      <= OP_INC;
      c_addr    <= '0;
      c_opnd    <= '0;
      c_ten     <= 1'b0;
      c_test    <= '0;
      c_tag     <= '0;
      vic_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_tag   <= '0;
      rsp_data  <= '0;
      get_valid <= 1'b0;
      get_addr  <= '0;
      put_valid <= 1'b0;
      put_addr  <= '0;
      put_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      get_valid <= 1'b0;
      put_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            c_op   <= atom_op_e'(cmd_op);
            c_addr <= cmd_addr;
            c_opnd <= cmd_operand;
            c_ten  <= cmd_test_en;
            c_test <= cmd_test;
            c_tag  <= cmd_tag;
            state  <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_data;
            rsp_tag   <= c_tag;
            if (push) begin
              put_valid <= 1'b1;
              put_addr  <= c_addr;
              put_data  <= new_val;
            end
            state <= ST_IDLE;
          end else begin
            get_valid <= 1'b1;
            get_addr  <= c_addr;
            vic_q     <= vic_idx;
            if (vic_dirty) begin
              put_valid <= 1'b1;
              put_addr  <= vic_tag;
              put_data  <= vic_data;
            end
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (fill_valid) state <= ST_LOOK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  pop_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R5
  hit_answers_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && hit) |=> (rsp_valid && cmd_ready));

  // R7
  no_rsp_after_get_chk: assert property (@(posedge clk) disable iff (rst)
    get_valid |=> !rsp_valid);

  // R10
  wb_other_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (put_valid && get_valid) |-> (put_addr != get_addr));

  // R4
  no_silent_put_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && hit && c_op == OP_INC && !c_ten) |=> !put_valid);
endmodule

// File: tb/test_atomic_unit.sv
module test_atomic_unit;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam int NE = 8;
  localparam int NA = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic          cmd_op = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_operand = '0;
  logic          cmd_test_en = 1'b0;
  logic [DW-1:0] cmd_test = '0;
  logic [TW-1:0] cmd_tag = '0;
  logic          rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_data;
  logic          get_valid;
  logic [AW-1:0] get_addr;
  logic          fill_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;
  logic          put_valid;
  logic [AW-1:0] put_addr;
  logic [DW-1:0] put_data;

  always #2 clk = ~clk;

  atomic_unit #(.AW(AW), .DW(DW), .TW(TW), .ENTRIES(NE)) i_atomic_unit (.*);

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] bmem [NA];   // backing memory
  logic [DW-1:0] mv   [NA];   // coherent value model
  int   lru_a [NE];
  bit   lru_d [NE];
  int   lru_n = 0;
  int   tagc  = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns 1 on hit; fills victim info on miss
  task automatic model_access(input int a, output bit hit, output bit wb,
                              output int wb_a);
    int pos = -1;
    bit d;
    wb = 0; wb_a = 0;
    for (int i = 0; i < lru_n; i++) if (lru_a[i] == a) pos = i;
    hit = (pos >= 0);
    if (hit) begin
      d = lru_d[pos];
      for (int i = pos; i > 0; i--) begin lru_a[i] = lru_a[i-1]; lru_d[i] = lru_d[i-1]; end
    end else begin
      d = 0;
      if (lru_n == NE) begin
        wb = lru_d[NE-1]; wb_a = lru_a[NE-1];
      end else lru_n++;
      for (int i = lru_n - 1; i > 0; i--) begin lru_a[i] = lru_a[i-1]; lru_d[i] = lru_d[i-1]; end
    end
    lru_a[0] = a; lru_d[0] = d;
  endtask

  task automatic do_cmd(input bit op, input int a, input logic [DW-1:0] opnd,
                        input bit ten, input logic [DW-1:0] tst);
    bit hit, wb, push, got_rsp, got_get, wb_seen, op_put_seen, extra;
    int wb_a, lat, fill_cnt;
    logic [DW-1:0] old_v, new_v, wb_data, op_put_data;
    logic [AW-1:0] wb_addr_seen, op_put_addr, gaddr;
    logic [TW-1:0] t;
    t = TW'(tagc); tagc++;
    model_access(a, hit, wb, wb_a);
    if (wb) wb_data = mv[wb_a];
    old_v = mv[a];
    new_v = old_v + (op ? opnd : DW'(1));
    push  = op || (ten && new_v == tst);
    mv[a] = new_v;
    lru_d[0] = !push;
    got_rsp = 0; got_get = 0; wb_seen = 0; op_put_seen = 0; extra = 0;
    fill_cnt = -1; lat = 0; gaddr = '0; wb_addr_seen = '0;
    op_put_addr = '0; op_put_data = '0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(a); cmd_operand = opnd;
    cmd_test_en = ten; cmd_test = tst; cmd_tag = t;
    @(posedge clk);
    while (!got_rsp && lat < 40) begin
      @(negedge clk);
      lat++;
      cmd_valid = 0;
      fill_valid = 0;
      if (lat == 1) chk(cmd_ready == 0, "R6 ready low while busy", cmd_ready, 0);
      if (fill_cnt > 0) begin
        fill_cnt--;
        if (fill_cnt == 0) begin fill_valid = 1; fill_data = bmem[gaddr]; end
      end
      if (get_valid) begin
        got_get = 1; gaddr = get_addr; fill_cnt = 2;
        if (put_valid) begin wb_seen = 1; wb_addr_seen = put_addr; end
        if (put_valid) bmem[put_addr] = put_data;
        if (put_valid) wb_data = (wb && put_addr == AW'(wb_a)) ? wb_data : ~put_data;
        if (put_valid) chk(put_data == wb_data, "R10 write-back data", put_data, wb_data);
      end else if (rsp_valid) begin
        got_rsp = 1;
        if (put_valid) begin
          op_put_seen = 1; op_put_addr = put_addr; op_put_data = put_data;
          bmem[put_addr] = put_data;
        end
      end else if (put_valid) extra = 1;
    end
    chk(got_rsp, "R6 response arrives", got_rsp, 1);
    chk(rsp_data == old_v, op ? "R2 old value" : "R1 old value", rsp_data, old_v);
    chk(rsp_tag == t, "R5 tag echo", rsp_tag, t);
    chk(cmd_ready == 1, "R6 ready with response", cmd_ready, 1);
    chk(!extra, "R8 no stray put", extra, 0);
    if (hit) begin
      chk(!got_get, "R8 no get on resident word", got_get, 0);
      chk(lat == 2, "R5 two-cycle hit", lat, 2);
    end else begin
      chk(got_get && gaddr == AW'(a), "R7 get address", gaddr, AW'(a));
      chk(wb_seen == wb, wb ? "R10 write-back issued" : "R11 no write-back",
          wb_seen, wb);
      if (wb) chk(wb_addr_seen == AW'(wb_a), "R9 victim address", wb_addr_seen, AW'(wb_a));
    end
    chk(op_put_seen == push,
        op ? "R2 put on fetch-add" : (ten ? "R3 put on test match" : "R4 no put without test"),
        op_put_seen, push);
    if (push) chk(op_put_addr == AW'(a) && op_put_data == new_v, "R3 put content",
                  op_put_data, new_v);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < NA; a++) begin
      bmem[a] = DW'(a * 3 + 5);
      mv[a]   = bmem[a];
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(cmd_ready == 1, "R12 ready after reset", cmd_ready, 1);
    chk(!rsp_valid && !get_valid && !put_valid, "R12 outputs idle",
        {rsp_valid, get_valid, put_valid}, 0);
    // R7 R9: misses into empty entries, then R1 R5 hits
    for (int a = 0; a < NE; a++) do_cmd(0, a, 0, 0, 0);
    for (int a = 0; a < NE; a++) do_cmd(0, a, 0, 0, 0);
    // R2 fetch-add on every resident word
    for (int a = 0; a < NE; a++) do_cmd(1, a, DW'(a * 1000 + 17), 0, 0);
    // dirty four words, then evict clean (R11) and dirty (R10) victims
    for (int a = 0; a < 4; a++) do_cmd(0, a, 0, 0, 0);
    for (int a = 8; a < 16; a++) do_cmd(0, a, 0, 0, 0);
    // re-read evicted words: values must come back from write-backs
    for (int a = 0; a < 4; a++) do_cmd(0, a, 0, 0, 0);
    // R3 barrier: four arrivals, one update
    for (int k = 0; k < 4; k++) do_cmd(0, 20, 0, 1, mv[20] + DW'(4 - k));
    do_cmd(0, 20, 0, 1, 32'h1234);               // R3 mismatch
    // R4 compare disabled even though value matches
    do_cmd(0, 20, 0, 0, mv[20] + 1);
    // R2 wrap-around
    do_cmd(1, 21, ~mv[21] + 4, 0, 0);
    // near-exhaustive sweep over ops, compare enable and addresses
    for (int a = 0; a < 24; a++)
      for (int k = 0; k < 4; k++)
        do_cmd(k[0], (a * 5 + k) % 24, DW'(a * 7 + k), k[1], mv[(a * 5 + k) % 24] + 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule